// File: doc/BRIEF.md
# Dual-Increment Fractional Clock Divider

This block is a single channel of a numerically controlled fractional clock divider. From one input clock it makes an output clock whose average period is a programmed, non-integer number of input cycles. The period is counted in half input cycles. Each output period lasts either a base number of half cycles, set by a divisor word, or one half cycle more. The top bit of a 32-bit phase accumulator chooses between the two lengths.

At the end of every output period the accumulator takes one of two increments, and its own top bit selects which one. Software sets the first increment to 2·Fin − div·Fout and the second to the first minus Fout. The accumulator then climbs while its top bit is clear and falls back once the bit is set. Over a long run this gives the exact requested ratio. Writing 0x8000_0000 as the initial accumulator value gives a neutral start.

The divider counts on a single clock edge. If a period ends on an odd half cycle, that half cycle is carried into the next period. The block drives an approximately 50% duty clock and a one-cycle tick that marks the start of each period. Registers are written and read through a simple word port.

Top module: `nco_frac_div`

## Requirements
- R1: While the enable bit (bit 31 of the control word) is clear, `nco_tick` and `nco_clk` are both low.
- R2: The registers sit at byte offsets 0 (control), 4 (divisor), 8 (first increment), 12 (second increment) and 16 (accumulator initial value). `bus_rdata` returns the register at `bus_addr` in the same cycle. Control reads back only bit 31, with the other bits zero. The divisor reads back its 13 stored bits, zero-extended. Other addresses read zero.
- R3: An output period lasts D half input cycles when accumulator bit 31 is clear and D+1 when it is set, where D is the effective divisor (bits [12:2] times 4 plus bits [1:0]). Each input cycle advances the count by two half cycles. A half cycle left over at the end of a period is carried into the next period.
- R4: At the end of each period the accumulator adds the first increment if its bit 31 is clear and the second increment if bit 31 is set, modulo 2^32. The length of the next period uses the updated bit 31.
- R5: `nco_tick` is high for exactly the first input cycle of each period. The first period begins in the cycle after the write that sets the enable bit.
- R6: `nco_clk` is high while the half-cycle position within the period is below half the period length, rounded down, and low for the rest of the period.
- R7: A control write that sets enable while it is clear loads the accumulator from the initial-value register and restarts the count at position zero.
- R8: A write to the divisor or to either increment while enabled leaves the current period unchanged and takes effect at the next period boundary.
- R9: An effective divisor below 8 is treated as 8.
- R10: After a synchronous active-low reset, the control, divisor and increment registers are zero, the initial value is 0x8000_0000, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| nco_tick | output | 1 | One-cycle pulse at each period start |
| nco_clk | output | 1 | Divided output clock, about 50% duty |

## Verification
The bench runs three kinds of divisor pattern. An even divisor with a small positive first increment shows whether the accumulator really alternates between short and long periods. An odd divisor makes every other period carry a half cycle, which exposes any error in the carry or in the tick position. A divisor below the minimum shows whether the clamp is applied. Mid-run rewrites of the divisor and increments, a disable followed by a re-enable with a different initial value, and a readback sweep over every register address separate errors in update timing from errors in the counting itself.

// File: rtl/nco_pkg.sv
// Package: shared register offsets for the fractional divider channel.
// Assumes byte addressing of 32-bit words on a 5-bit offset bus.
package nco_pkg;
    localparam int OFS_W = 5;

    typedef enum logic [OFS_W-1:0] {
        OFS_CTRL  = 5'd0,
        OFS_DIV   = 5'd4,
        OFS_STEPA = 5'd8,
        OFS_STEPB = 5'd12,
        OFS_SEED  = 5'd16
    } nco_ofs_e;
endpackage

// File: rtl/nco_regs.sv
// Register file for one divider channel: enable, raw divisor, two
// increments and the accumulator seed. It also flags the write that turns
// the channel on. Assumes single-cycle writes and combinational reads.
module nco_regs
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int DIV_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFS_W-1:0]  addr,
    input  logic [ACC_W-1:0]  wdata,
    output logic [ACC_W-1:0]  rdata,
    output logic              en,
    output logic              start,
    output logic [DIV_W-1:0]  div_raw,
    output logic [ACC_W-1:0]  step_a,
    output logic [ACC_W-1:0]  step_b,
    output logic [ACC_W-1:0]  seed
);
    localparam logic [ACC_W-1:0] SEED_RST = {1'b1, {(ACC_W-1){1'b0}}};

    // Purpose: detect the write that turns a stopped channel on.
    always_comb start = we && (addr == OFS_CTRL) && wdata[ACC_W-1] && !en;

    // Purpose: capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            div_raw <= '0;
            step_a  <= '0;
            step_b  <= '0;
            seed    <= SEED_RST;
        end else if (we) begin
            case (addr)
                OFS_CTRL:  en      <= wdata[ACC_W-1];
                OFS_DIV:   div_raw <= wdata[DIV_W-1:0];
                OFS_STEPA: step_a  <= wdata;
                OFS_STEPB: step_b  <= wdata;
                OFS_SEED:  seed    <= wdata;
                default:   ;
            endcase
        end
    end

    // Purpose: return the addressed register.
    always_comb begin
        case (addr)
            OFS_CTRL:  rdata = {en, {(ACC_W-1){1'b0}}};
            OFS_DIV:   rdata = {{(ACC_W-DIV_W){1'b0}}, div_raw};
            OFS_STEPA: rdata = step_a;
            OFS_STEPB: rdata = step_b;
            OFS_SEED:  rdata = seed;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/nco_accum.sv
// Phase accumulator: steps once per output period by one of two increments,
// chosen by its own top bit. Assumes `boundary` is high for exactly one
// cycle per period and `start` overrides it.
module nco_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             boundary,
    input  logic [ACC_W-1:0] seed,
    input  logic [ACC_W-1:0] step_a,
    input  logic [ACC_W-1:0] step_b,
    output logic [ACC_W-1:0] acc,
    output logic             next_msb
);
    logic [ACC_W-1:0] sum;

    // Purpose: form the wrapped sum for the selected increment.
    always_comb begin
        sum      = acc + (acc[ACC_W-1] ? step_b : step_a);
        next_msb = sum[ACC_W-1];
    end

    // Purpose: load the seed on start, step at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc <= '0;
        else if (start)    acc <= seed;
        else if (boundary) acc <= sum;
    end

    // R4: the accumulator moves only at a boundary or a start
    a_r4_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !start) |=> $stable(acc));
endmodule

// File: rtl/nco_period.sv
// Period counter in half input cycles. Each cycle adds two half cycles. At
// the end of a period the overshoot (0 or 1) becomes the next start
// position. Length = clamped divisor + accumulator top bit. Assumes
// MIN_DIV >= 4.
module nco_period #(
    parameter int DIV_W   = 13,
    parameter int MIN_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic [DIV_W-1:0] div_raw,
    input  logic             seed_msb,
    input  logic             next_msb,
    output logic             boundary,
    output logic             tick,
    output logic             clk_o
);
    localparam int LEN_W = DIV_W + 1;
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_DIV);

    logic [LEN_W-1:0] pos, len, div_eff;
    logic [LEN_W:0]   pos_adv;

    // Purpose: clamp the programmed divisor to the legal minimum.
    always_comb begin
        div_eff = ({1'b0, div_raw} < LEN_MIN) ? LEN_MIN : {1'b0, div_raw};
    end

    // Purpose: detect the last input cycle of the current period.
    always_comb begin
        pos_adv  = {1'b0, pos} + (LEN_W+1)'(2);
        boundary = en && (pos_adv >= {1'b0, len});
    end

    // Purpose: advance the position and fix the next period length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            len <= LEN_MIN;
        end else if (start) begin
            pos <= '0;
            len <= div_eff + LEN_W'(seed_msb);
        end else if (boundary) begin
            pos <= LEN_W'(pos_adv - {1'b0, len});
            len <= div_eff + LEN_W'(next_msb);
        end else if (en) begin
            pos <= LEN_W'(pos_adv);
        end
    end

    // Purpose: drive the tick and the divided clock.
    always_comb begin
        tick  = en && (pos < LEN_W'(2));
        clk_o = en && (pos < (len >> 1));
    end

    // R3: position never reaches the period length
    a_r3_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pos < len));
    // R9: a period is never shorter than the minimum
    a_r9_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (len >= LEN_MIN));
endmodule

// File: rtl/nco_frac_div.sv
// Top of one fractional divider channel: register file, period counter and
// phase accumulator. Assumes the bus is synchronous to clk.
module nco_frac_div #(
    parameter int ACC_W   = 32,
    parameter int DIV_W   = 13,
    parameter int MIN_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        nco_tick,
    output logic        nco_clk
);
    logic             en, start, boundary, next_msb;
    logic [DIV_W-1:0] div_raw;
    logic [ACC_W-1:0] step_a, step_b, seed, acc;

    nco_regs #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .en(en), .start(start),
        .div_raw(div_raw), .step_a(step_a), .step_b(step_b), .seed(seed)
    );

    nco_period #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_period (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start), .div_raw(div_raw),
        .seed_msb(seed[ACC_W-1]), .next_msb(next_msb),
        .boundary(boundary), .tick(nco_tick), .clk_o(nco_clk)
    );

    nco_accum #(.ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .start(start), .boundary(boundary),
        .seed(seed), .step_a(step_a), .step_b(step_b),
        .acc(acc), .next_msb(next_msb)
    );

    // R1: a stopped channel drives nothing
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!nco_tick && !nco_clk));
    // R7: turning on loads the seed into the accumulator
    a_r7_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc == $past(seed)));
    // R5: every period end is followed by a tick unless the channel stops
    a_r5_tick_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !start) |=> (!en || nco_tick));
endmodule

// File: tb/nco_frac_div_bench.sv
// Bench: a behavioural model advanced on each rising edge, compared with
// the design on each falling edge.
module nco_frac_div_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = 5'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        nco_tick, nco_clk;

    nco_frac_div u_nco_frac_div (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nco_tick(nco_tick), .nco_clk(nco_clk)
    );

    always #4 clk = ~clk;

    // reference model state
    bit          m_en = 0;
    int          m_pos = 0, m_len = 8;
    bit   [31:0] m_acc = 0, m_div = 0, m_sa = 0, m_sb = 0, m_seed = 32'h8000_0000;
    int          vectors = 0, errors = 0, cyc = 0;
    bit          chk_on = 0, done = 0;
    string       phase = "R10 reset";

    function automatic int eff(bit [31:0] d);
        return (d < 8) ? 8 : int'(d);
    endfunction

    function automatic bit [31:0] model_read(bit [4:0] a);
        case (a)
            5'd0:  return {m_en, 31'd0};
            5'd4:  return m_div;
            5'd8:  return m_sa;
            5'd12: return m_sb;
            5'd16: return m_seed;
            default: return 32'd0;
        endcase
    endfunction

    // model: period end first (R3, R4, R8), then register writes (R2, R7)
    always @(posedge clk) begin
        bit [31:0] nxt;
        if (!rst_n) begin
            m_en = 0; m_pos = 0; m_len = 8; m_acc = 0;
            m_div = 0; m_sa = 0; m_sb = 0; m_seed = 32'h8000_0000;
        end else begin
            if (m_en && (m_pos + 2 >= m_len)) begin
                nxt   = m_acc + (m_acc[31] ? m_sb : m_sa);
                m_pos = m_pos + 2 - m_len;
                m_len = eff(m_div) + int'(nxt[31]);
                m_acc = nxt;
            end else if (m_en) begin
                m_pos = m_pos + 2;
            end
            if (bus_we) begin
                case (bus_addr)
                    5'd0: begin
                        if (bus_wdata[31] && !m_en) begin
                            m_acc = m_seed; m_pos = 0;
                            m_len = eff(m_div) + int'(m_seed[31]);
                        end
                        m_en = bus_wdata[31];
                    end
                    5'd4:  m_div  = {19'd0, bus_wdata[12:0]};
                    5'd8:  m_sa   = bus_wdata;
                    5'd12: m_sb   = bus_wdata;
                    5'd16: m_seed = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // compare on the falling edge
    always @(negedge clk) begin
        bit e_tick, e_clk;
        bit [31:0] e_rd;
        if (chk_on && !done) begin
            e_tick = m_en && (m_pos < 2);
            e_clk  = m_en && (m_pos < (m_len / 2));
            e_rd   = model_read(bus_addr);
            vectors++;
            if (nco_tick !== e_tick) begin
                errors++;
                $display("FAIL R5 [%s] cyc %0d tick act=%b exp=%b", phase, cyc, nco_tick, e_tick);
            end
            if (nco_clk !== e_clk) begin
                errors++;
                $display("FAIL R6 [%s] cyc %0d clk act=%b exp=%b", phase, cyc, nco_clk, e_clk);
            end
            if (bus_rdata !== e_rd) begin
                errors++;
                $display("FAIL R2 [%s] cyc %0d rdata@%0d act=%h exp=%h", phase, cyc, bus_addr, bus_rdata, e_rd);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    // run n cycles, sweeping the read address over the register map (R2)
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            bus_addr = 5'((i % 6) * 4);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        chk_on = 1;           // R10: outputs and registers at reset values
        #2 rst_n = 1'b1;
        run(12);

        phase = "R3 R4 even divisor";
        wr(5'd4, 32'd10);
        wr(5'd8, 32'h0400_0000);
        wr(5'd12, 32'hF400_0000);
        wr(5'd16, 32'h8000_0000);
        wr(5'd0, 32'h8000_0000);   // R7 start
        run(400);

        phase = "R8 rewrite while enabled";
        wr(5'd4, 32'd13);           // odd divisor, R3 carry
        wr(5'd8, 32'h1000_0000);
        wr(5'd12, 32'hE000_0000);
        run(400);

        phase = "R1 disabled";
        wr(5'd0, 32'h0000_0000);
        run(40);

        phase = "R9 clamp";
        wr(5'd4, 32'd3);
        wr(5'd16, 32'h0000_0000);
        wr(5'd0, 32'hFFFF_FFFF);    // R7 restart with a clear seed top bit
        run(300);

        phase = "R7 re-enable ignored while on";
        wr(5'd16, 32'h8000_0000);
        wr(5'd0, 32'h8000_0000);    // already on: no reload
        run(100);

        phase = "R2 unmapped address";
        wr(5'd20, 32'h1234_5678);
        run(30);

        phase = "R10 reset again";
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        run(12);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule